// File: doc/BRIEF.md
# Interrupt Source Capture Register Bank

This block receives a parameterised number of asynchronous interrupt request lines (up to 512, 64 by default). For each line it keeps an enable bit, a polarity bit, a sensitivity-type bit and a pending flag. Each request line first passes through a two-flop synchroniser. An edge-sensitive source latches its pending flag on the selected transition and keeps it until software clears it. A level-sensitive source shows the qualified input level directly as its pending flag.

Software reaches the bank through a single-cycle memory-mapped port: `req_i` with `we_i` high is a write, and `req_i` with `we_i` low is a read whose data appears on `rdata_o` one clock later. Single enable bits and single pending flags are changed by writing a source number to an indexed control register. Whole 32-bit words of enables or pending flags are cleared through per-word clear registers. The output `irq_o` holds the pending flags ANDed with the enables, all gated by one global enable. Channel mapping and prioritisation are handled downstream.

Address layout, in word addresses: `addr_i[7:4]` selects a region and `addr_i[3:0]` selects a control register or word index w. Source n sits in word n/32, bit n mod 32. Region 0 holds the control registers: 0x00 global enable (bit 0), 0x01 indexed enable set, 0x02 indexed enable clear, 0x03 indexed pending clear, 0x04 indexed pending set. The other regions are 0x10+w enable word clear, 0x20+w pending word clear, 0x30+w polarity, 0x40+w type, 0x50+w raw pending (read-only), 0x60+w masked pending (read-only) and 0x70+w enable (read-only).

Top module: `isc_bank`

## Requirements
- R1: After reset the global enable, all enables and all pending flags are 0, every polarity bit is 1, every type bit is 0, and `irq_o` is 0.
- R2: Writing source number n to 0x01 sets only enable n. Writing n to 0x02 clears only enable n. The result is visible at 0x70+w.
- R3: An indexed write (0x01, 0x02, 0x04) whose full 32-bit data is at or above NUM_SRC changes nothing, even when the low bits of the data would name a valid source.
- R4: A write to 0x10+w clears every enable bit of word w that is written as 1. A write to 0x20+w clears every edge pending flag of word w that is written as 1. Bits written as 0 are unchanged.
- R5: With type bit 0 (level), the pending flag equals the synchronised input when polarity is 1, and its inverse when polarity is 0. A pending clear of any kind leaves it set while the level stays active.
- R6: With type bit 1 (edge), a 0-to-1 transition (polarity 1) or a 1-to-0 transition (polarity 0) sets the pending flag. The flag then holds after the input returns, until it is cleared by writing n to 0x03 or through 0x20+w. If an edge and a clear arrive in the same cycle, the edge wins.
- R7: Polarity (0x30+w) and type (0x40+w) words are read/write. Bit b of word w controls source 32*w+b.
- R8: `irq_o` is all zeros while global enable (0x00 bit 0) is 0, and pending AND enable while it is 1.
- R9: 0x50+w returns the pending flags regardless of enables. 0x60+w returns the pending flags ANDed with the enables.
- R10: Writing n to 0x04 sets the pending flag of edge source n. For a level source it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous interrupt request lines |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | NUM_SRC | Enabled pending interrupts |

## Verification
Assertions check on every cycle that an indexed enable set or clear lands on exactly the named bit, and that an out-of-range index leaves the enables untouched. They also check that a detected edge always sets its latch even when a clear arrives in the same cycle, and that a set latch holds while no clear is present. Only the bench scenarios can show the full signal path: the synchroniser delay, level tracking under both polarities, edge capture after the input has returned, the bit-to-word mapping of the polarity and type registers, and the word-clear, masked-read and global gating behaviour seen at the ports.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int DW = 32;
  localparam int AW = 8;

  typedef enum logic [3:0] {
    RG_CTRL   = 4'h0,
    RG_EN_CLR = 4'h1,
    RG_ST_CLR = 4'h2,
    RG_POL    = 4'h3,
    RG_TYPE   = 4'h4,
    RG_RAW    = 4'h5,
    RG_MSK    = 4'h6,
    RG_EN     = 4'h7
  } region_e;

  localparam logic [3:0] CTL_GLOBAL = 4'h0;
  localparam logic [3:0] CTL_EN_SET = 4'h1;
  localparam logic [3:0] CTL_EN_CLR = 4'h2;
  localparam logic [3:0] CTL_ST_CLR = 4'h3;
  localparam logic [3:0] CTL_ST_SET = 4'h4;
endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/isc_detect.sv
module isc_detect #(
  parameter int N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] type_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic prev_q, lat_q, lat_d, hit;

    always_comb begin
      hit = pol_i[g] ? (sync_i[g] & ~prev_q) : (~sync_i[g] & prev_q);
      if (!type_i[g])               lat_d = 1'b0;
      else if (hit || set_i[g])     lat_d = 1'b1;  // capture beats clear
      else if (clr_i[g])            lat_d = 1'b0;
      else                          lat_d = lat_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        prev_q <= sync_i[g];
        lat_q  <= lat_d;
      end
    end

    assign pend_o[g] = type_i[g] ? lat_q : (pol_i[g] ? sync_i[g] : ~sync_i[g]);

    AST_EDGE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_i[g] && hit) |=> lat_q) else $error("edge lost");  // R6
    AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_i[g] && lat_q && !clr_i[g]) |=> lat_q) else $error("latch dropped");  // R6
  end
endmodule

// File: rtl/isc_regs.sv
module isc_regs
  import isc_pkg::*;
#(
  parameter int N = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  pend_i,
  output logic [DW-1:0] rdata_o,
  output logic          glb_o,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  pol_o,
  output logic [N-1:0]  type_o,
  output logic [N-1:0]  st_clr_o,
  output logic [N-1:0]  st_set_o
);
  localparam int NW  = (N + DW - 1) / DW;
  localparam int PAD = NW * DW;
  localparam int IW  = (N > 1) ? $clog2(N) : 1;

  region_e    rg;
  logic [3:0] widx;
  logic       wr, rd, wr_ctl, idx_ok;
  logic [N-1:0] idx_hot, wsel, wmask;
  logic [N-1:0] en_set, en_clr;
  logic [N-1:0] en_q, pol_q, type_q;
  logic         glb_q;
  logic [DW-1:0] rdata_q;

  assign rg     = region_e'(addr_i[7:4]);
  assign widx   = addr_i[3:0];
  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign wr_ctl = wr && (rg == RG_CTRL);
  assign idx_ok = (wdata_i < DW'(N));

  for (genvar b = 0; b < N; b++) begin : g_bit
    assign idx_hot[b] = idx_ok && (wdata_i[IW-1:0] == IW'(b));
    assign wsel[b]    = (widx == 4'(b / DW));
    assign wmask[b]   = wsel[b] & wdata_i[b % DW];
  end

  assign en_set   = (wr_ctl && widx == CTL_EN_SET) ? idx_hot : '0;
  assign en_clr   = ((wr_ctl && widx == CTL_EN_CLR) ? idx_hot : '0)
                  | ((wr && rg == RG_EN_CLR) ? wmask : '0);
  assign st_clr_o = ((wr_ctl && widx == CTL_ST_CLR) ? idx_hot : '0)
                  | ((wr && rg == RG_ST_CLR) ? wmask : '0);
  assign st_set_o = (wr_ctl && widx == CTL_ST_SET) ? idx_hot : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q  <= 1'b0;
      en_q   <= '0;
      pol_q  <= '1;
      type_q <= '0;
    end else begin
      en_q <= (en_q | en_set) & ~en_clr;
      if (wr_ctl && widx == CTL_GLOBAL) glb_q <= wdata_i[0];
      if (wr && rg == RG_POL)  pol_q  <= (pol_q  & ~wsel) | wmask;
      if (wr && rg == RG_TYPE) type_q <= (type_q & ~wsel) | wmask;
    end
  end

  function automatic logic [DW-1:0] pick(input logic [N-1:0] v, input logic [3:0] i);
    logic [PAD-1:0] p;
    p    = PAD'(v);
    pick = '0;
    for (int w = 0; w < NW; w++) if (i == 4'(w)) pick = p[w*DW +: DW];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) begin
      case (rg)
        RG_CTRL: rdata_q <= (widx == CTL_GLOBAL) ? DW'(glb_q) : '0;
        RG_POL:  rdata_q <= pick(pol_q, widx);
        RG_TYPE: rdata_q <= pick(type_q, widx);
        RG_RAW:  rdata_q <= pick(pend_i, widx);
        RG_MSK:  rdata_q <= pick(pend_i & en_q, widx);
        RG_EN:   rdata_q <= pick(en_q, widx);
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign glb_o   = glb_q;
  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign type_o  = type_q;

  AST_EN_SET_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && widx == CTL_EN_SET && idx_ok) |=> ((en_q & $past(idx_hot)) == $past(idx_hot)))
    else $error("enable set missed");  // R2
  AST_EN_CLR_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && widx == CTL_EN_CLR && idx_ok) |=> ((en_q & $past(idx_hot)) == '0))
    else $error("enable clear missed");  // R2
  AST_BAD_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && !idx_ok && (widx == CTL_EN_SET || widx == CTL_EN_CLR)) |=> $stable(en_q))
    else $error("out-of-range index acted");  // R3
endmodule

// File: rtl/isc_bank.sv
module isc_bank
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [7:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_SRC-1:0] irq_o
);
  logic [NUM_SRC-1:0] sync_w, pend_w, en_w, pol_w, type_w, clr_w, set_w;
  logic               glb_w;

  isc_sync #(.W(NUM_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (sync_w)
  );

  isc_detect #(.N(NUM_SRC)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_w),
    .pol_i (pol_w),
    .type_i(type_w),
    .clr_i (clr_w),
    .set_i (set_w),
    .pend_o(pend_w)
  );

  isc_regs #(.N(NUM_SRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pend_i  (pend_w),
    .rdata_o (rdata_o),
    .glb_o   (glb_w),
    .en_o    (en_w),
    .pol_o   (pol_w),
    .type_o  (type_w),
    .st_clr_o(clr_w),
    .st_set_o(set_w)
  );

  assign irq_o = glb_w ? (pend_w & en_w) : '0;
endmodule

// File: tb/sim_isc_bank.sv
`timescale 1ns/1ps
module sim_isc_bank;
  localparam int N = 40;
  localparam logic [N-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic         req = 1'b0, we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [N-1:0] irq;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  isc_bank #(.NUM_SRC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic rd40(input logic [3:0] region, output logic [N-1:0] v);
    logic [31:0] lo, hi;
    rd({region, 4'h0}, lo);
    rd({region, 4'h1}, hi);
    v = {hi[N-33:0], lo};
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic done();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    done();
  end

  initial begin
    logic [N-1:0] v, exp, p1, p2;
    logic [31:0]  d;
    p1 = 40'hA5_3C96_0F71;
    p2 = 40'h3C_5A5A_0FF0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 64'(irq), 64'(0));
    rd(8'h00, d);   chk("R1 global", 64'(d), 64'(0));
    rd40(4'h3, v);  chk("R1 polarity", 64'(v), 64'(MASK));
    rd40(4'h4, v);  chk("R1 type", 64'(v), 64'(0));
    rd40(4'h7, v);  chk("R1 enable", 64'(v), 64'(0));
    rd40(4'h5, v);  chk("R1 raw", 64'(v), 64'(0));

    // R2 indexed set sweep, then indexed clear sweep
    for (int i = 0; i < N; i++) begin
      wr(8'h01, 32'(i));
      rd40(4'h7, v);
      chk("R2 set", 64'(v), 64'((41'(1) << (i + 1)) - 1));
    end
    for (int i = 0; i < N; i++) begin
      wr(8'h02, 32'(i));
      rd40(4'h7, v);
      chk("R2 clr", 64'(v), 64'(MASK & ~40'((41'(1) << (i + 1)) - 1)));
    end

    // R3 out-of-range index, including low bits aliasing a valid source
    wr(8'h01, 32'd40); wr(8'h01, 32'd64); wr(8'h01, 32'd69);
    rd40(4'h7, v); chk("R3 set ignored", 64'(v), 64'(0));
    for (int i = 0; i < N; i++) wr(8'h01, 32'(i));
    wr(8'h02, 32'd40); wr(8'h02, 32'd63); wr(8'h02, 32'hFFFF_FFFF); wr(8'h02, 32'h100);
    rd40(4'h7, v); chk("R3 clr ignored", 64'(v), 64'(MASK));

    // R5 level high, R8 gating, R9 raw read
    src = p1; settle();
    chk("R8 global off", 64'(irq), 64'(0));
    rd40(4'h5, v); chk("R9 raw ungated", 64'(v), 64'(p1));
    wr(8'h00, 32'h1);
    chk("R5 level high", 64'(irq), 64'(p1));
    rd(8'h00, d); chk("R8 global read", 64'(d), 64'(1));
    wr(8'h03, 32'd0); settle();
    chk("R5 idx clear on active level", 64'(irq), 64'(p1));
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h21, 32'hFF); settle();
    chk("R5 word clear on active level", 64'(irq), 64'(p1));

    // R5/R7 level low and per-bit layout
    wr(8'h30, 32'h0); wr(8'h31, 32'h0); settle();
    chk("R5 level low", 64'(irq), 64'(~p1 & MASK));
    wr(8'h31, 32'h1); settle();
    exp = ~p1 & MASK; exp[32] = p1[32];
    chk("R7 bit32 polarity", 64'(irq), 64'(exp));
    rd40(4'h3, v); chk("R7 polarity read", 64'(v), 64'(40'h01_0000_0000));

    // R4 word enable clear, R9 masked read
    wr(8'h10, 32'h0000_FFFF);
    rd40(4'h7, v); chk("R4 enable word clr", 64'(v), 64'(MASK & ~40'hFFFF));
    rd40(4'h6, v); chk("R9 masked", 64'(v), 64'(exp & ~40'hFFFF));
    chk("R8 irq masked", 64'(irq), 64'(exp & ~40'hFFFF));
    wr(8'h11, 32'h0000_0003);
    rd40(4'h7, v); chk("R4 enable word1 clr", 64'(v), 64'(MASK & ~40'hFFFF & ~40'h03_0000_0000));
    for (int i = 0; i < N; i++) wr(8'h01, 32'(i));

    // R6 rising edge
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h31, 32'hFF);
    src = '0; settle();
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h41, 32'hFF); settle();
    rd40(4'h4, v); chk("R7 type read", 64'(v), 64'(MASK));
    chk("R6 idle", 64'(irq), 64'(0));
    src = p1; settle(); chk("R6 rise capture", 64'(irq), 64'(p1));
    src = '0; settle(); chk("R6 held", 64'(irq), 64'(p1));
    wr(8'h03, 32'd0); settle();
    chk("R6 idx clear", 64'(irq), 64'(p1 & ~40'h1));
    wr(8'h03, 32'd64); settle();
    chk("R3 bad idx clear", 64'(irq), 64'(p1 & ~40'h1));
    wr(8'h20, 32'h0000_00F0); settle();
    chk("R4 status word0 clr", 64'(irq), 64'(p1 & ~40'hF1));
    wr(8'h21, 32'hFFFF_FFFF); settle();
    chk("R4 status word1 clr", 64'(irq), 64'(p1 & 40'h00_FFFF_FF0E));
    wr(8'h20, 32'hFFFF_FFFF); settle();
    chk("R4 all clear", 64'(irq), 64'(0));

    // R6 falling edge
    wr(8'h30, 32'h0); wr(8'h31, 32'h0);
    src = MASK; settle(); chk("R6 rise ignored in fall mode", 64'(irq), 64'(0));
    src = p2; settle(); chk("R6 fall capture", 64'(irq), 64'(~p2 & MASK));
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h21, 32'hFF); settle();
    src = MASK; settle();
    chk("R6 cleared", 64'(irq), 64'(0));

    // R10 indexed pending set
    wr(8'h04, 32'd5); settle();
    chk("R10 set edge", 64'(irq), 64'(40'h20));
    wr(8'h04, 32'd69); wr(8'h04, 32'd40); settle();
    chk("R3 bad idx set", 64'(irq), 64'(40'h20));
    wr(8'h41, 32'h0); settle();
    wr(8'h04, 32'd35); settle();
    chk("R10 set on level ignored", 64'(irq), 64'(40'h20));
    rd40(4'h5, v); chk("R10 raw after set", 64'(v), 64'(40'h20));

    done();
  end
endmodule